// File: doc/BRIEF.md
# ATM Transmit Cell Source Selector

This block fills every 53-byte cell slot on a transmit byte stream headed for a SONET STS-3c payload mapper. Each slot is given to one of three sources in fixed priority. User cells from the transmit FIFO come first. Cells staged by a microprocessor in the cell insertion buffer come next. When neither source has anything, the block makes an idle cell itself, so the stream never runs dry.

Both upstream sources are show-ahead byte stores. Each one reports whether it holds at least one complete cell, and each one presents its head byte. The block pulses a read strobe for every byte it accepts from a source. The idle cell is built from five programmable header bytes and one programmable fill byte that is used for all 48 payload bytes. A microprocessor writes these values through a small write port. After reset they hold the standard idle-cell pattern.

The output moves forward by one byte in each cycle that the downstream ready input is high. The output carries a start-of-cell marker and a code that names the source of the current cell.

Top module: `atm_tx_cell_sel`

## Requirements
- R1: At a cell boundary, when `user_cell_rdy` is high, the cell is taken from the transmit FIFO (`tx_src` = 0). A FIFO holding only part of a cell does not raise `user_cell_rdy` and is never started.
- R2: At a cell boundary, when `user_cell_rdy` is low and `ins_cell_rdy` is high, the cell is taken from the insertion buffer (`tx_src` = 1).
- R3: When both ready flags are low at a cell boundary, an idle cell is sent (`tx_src` = 2), so that every slot carries a cell.
- R4: After reset, an idle cell is header bytes 0x00, 0x00, 0x00, 0x01, 0x52 followed by 48 bytes of 0x6A.
- R5: A write with `cfg_addr` 0 to 4 sets idle header byte 0 to 4. Byte 0 is sent first.
- R6: A write with `cfg_addr` 5 sets the fill value used for every idle payload byte.
- R7: The source is chosen only at a cell boundary. All 53 bytes of a cell come from that source, even when a higher-priority source becomes ready partway through.
- R8: When `tx_ready` is low, the output byte, marker and source hold their values, and no read strobe is raised.
- R9: `tx_soc` is high on the first header byte of each cell and low on the other 52 bytes.
- R10: A configuration write made during an idle cell changes only later idle cells. The cell already in flight keeps its old bytes.
- R11: `user_rd` or `ins_rd` pulses exactly when a byte from that source is accepted. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| user_cell_rdy | input | 1 | Transmit FIFO holds at least one complete cell |
| user_byte | input | 8 | Head byte of the transmit FIFO |
| user_rd | output | 1 | Pops one byte from the transmit FIFO |
| ins_cell_rdy | input | 1 | Insertion buffer holds at least one complete cell |
| ins_byte | input | 8 | Head byte of the insertion buffer |
| ins_rd | output | 1 | Pops one byte from the insertion buffer |
| cfg_we | input | 1 | Idle-pattern register write strobe |
| cfg_addr | input | 3 | 0 to 4 select a header byte, 5 selects the fill byte |
| cfg_wdata | input | 8 | Write data |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_byte | output | 8 | Output byte |
| tx_soc | output | 1 | First byte of a cell |
| tx_src | output | 2 | Source of the current cell: 0 FIFO, 1 insertion, 2 idle |

## Verification
The bench builds the block with the default 53-byte cell and 5-byte header. Every scenario therefore runs over full-length cells, and the payload-fill address sits at 5.

With cells this long, the bench can do three things well inside a cell that is already in flight:
- complete a partly written FIFO cell,
- hold the output in a stall,
- rewrite the idle registers.

This exposes any early switch of source, any mixing of old and new idle bytes, and any pop during a stall.

// File: rtl/atm_sel_pkg.sv
package atm_sel_pkg;
  typedef enum logic [1:0] {
    SRC_USER = 2'd0,
    SRC_INS  = 2'd1,
    SRC_IDLE = 2'd2
  } cell_src_e;
endpackage

// File: rtl/atm_cell_pos.sv
// Byte position inside the current cell slot.
module atm_cell_pos #(
  parameter int CELL_BYTES = 53,
  parameter int IDX_W      = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] pos,
  output logic             first
);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] pos_nxt;

  assign first = (pos == '0);

  always_comb begin
    pos_nxt = pos;
    if (adv) begin
      pos_nxt = (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end
endmodule

// File: rtl/atm_src_arb.sv
// Strict-priority source pick, frozen for the rest of the cell.
module atm_src_arb
  import atm_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      user_rdy,
  input  logic      ins_rdy,
  input  logic      first,
  input  logic      adv,
  output cell_src_e cur_src
);
  cell_src_e pick, held_q, held_d;

  always_comb begin
    if (user_rdy)     pick = SRC_USER;
    else if (ins_rdy) pick = SRC_INS;
    else              pick = SRC_IDLE;
  end

  always_comb begin
    held_d = held_q;
    if (first && adv) held_d = pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= SRC_IDLE;
    else        held_q <= held_d;
  end

  assign cur_src = first ? pick : held_q;
endmodule

// File: rtl/atm_idle_gen.sv
// Programmable idle cell: live registers plus a per-cell shadow copy.
module atm_idle_gen #(
  parameter int                      HDR_BYTES = 5,
  parameter int                      IDX_W     = 6,
  parameter int                      CFG_AW    = 3,
  parameter logic [HDR_BYTES*8-1:0]  HDR_INIT  = 40'h00_00_00_01_52,
  parameter logic [7:0]              FILL_INIT = 8'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [IDX_W-1:0]  pos,
  input  logic              first,
  input  logic              adv,
  output logic [7:0]        idle_byte
);
  localparam logic [CFG_AW-1:0] FILL_ADDR = CFG_AW'(HDR_BYTES);

  logic [7:0] hdr_q [HDR_BYTES];
  logic [7:0] hdr_d [HDR_BYTES];
  logic [7:0] hsh_q [HDR_BYTES];
  logic [7:0] hsh_d [HDR_BYTES];
  logic [7:0] fill_q, fill_d, fsh_q, fsh_d;

  always_comb begin
    hdr_d  = hdr_q;
    hsh_d  = hsh_q;
    fill_d = fill_q;
    fsh_d  = fsh_q;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (cfg_we && (cfg_addr == CFG_AW'(i))) hdr_d[i] = cfg_wdata;
    end
    if (cfg_we && (cfg_addr == FILL_ADDR)) fill_d = cfg_wdata;
    // snapshot taken as the first byte leaves, before any same-cycle write lands
    if (first && adv) begin
      hsh_d = hdr_q;
      fsh_d = fill_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_BYTES; i++) begin
        hdr_q[i] <= HDR_INIT[(HDR_BYTES-1-i)*8 +: 8];
        hsh_q[i] <= HDR_INIT[(HDR_BYTES-1-i)*8 +: 8];
      end
      fill_q <= FILL_INIT;
      fsh_q  <= FILL_INIT;
    end else begin
      hdr_q  <= hdr_d;
      hsh_q  <= hsh_d;
      fill_q <= fill_d;
      fsh_q  <= fsh_d;
    end
  end

  always_comb begin
    idle_byte = first ? fill_q : fsh_q;
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (pos == IDX_W'(i)) idle_byte = first ? hdr_q[i] : hsh_q[i];
    end
  end
endmodule

// File: rtl/atm_tx_cell_sel.sv
module atm_tx_cell_sel
  import atm_sel_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 5,
  localparam int CFG_AW    = $clog2(HDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              user_cell_rdy,
  input  logic [7:0]        user_byte,
  output logic              user_rd,
  input  logic              ins_cell_rdy,
  input  logic [7:0]        ins_byte,
  output logic              ins_rd,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              tx_ready,
  output logic [7:0]        tx_byte,
  output logic              tx_soc,
  output logic [1:0]        tx_src
);
  localparam int IDX_W = $clog2(CELL_BYTES);

  logic [IDX_W-1:0] pos;
  logic             first;
  logic             adv;
  cell_src_e        cur_src;
  logic [7:0]       idle_byte;

  assign adv = tx_ready;

  atm_cell_pos #(.CELL_BYTES(CELL_BYTES), .IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv), .pos(pos), .first(first)
  );

  atm_src_arb u_arb (
    .clk(clk), .rst_n(rst_n), .user_rdy(user_cell_rdy), .ins_rdy(ins_cell_rdy),
    .first(first), .adv(adv), .cur_src(cur_src)
  );

  atm_idle_gen #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W), .CFG_AW(CFG_AW)) u_idle (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pos(pos), .first(first), .adv(adv),
    .idle_byte(idle_byte)
  );

  always_comb begin
    unique case (cur_src)
      SRC_USER: tx_byte = user_byte;
      SRC_INS:  tx_byte = ins_byte;
      default:  tx_byte = idle_byte;
    endcase
  end

  assign user_rd = adv && (cur_src == SRC_USER);
  assign ins_rd  = adv && (cur_src == SRC_INS);
  assign tx_soc  = first;
  assign tx_src  = cur_src;
endmodule

// File: rtl/atm_tx_cell_sel_chk.sv
module atm_tx_cell_sel_chk #(
  parameter int CELL_BYTES = 53
) (
  input logic       clk,
  input logic       rst_n,
  input logic       user_cell_rdy,
  input logic       ins_cell_rdy,
  input logic       user_rd,
  input logic       ins_rd,
  input logic       tx_ready,
  input logic       tx_soc,
  input logic [1:0] tx_src
);
  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(CELL_BYTES - 1);

  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (tx_ready) cnt <= (cnt == LAST_POS) ? '0 : cnt + 1'b1;
  end

  // R1
  user_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_soc && user_cell_rdy) |-> (tx_src == 2'd0));
  // R2
  ins_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_soc && !user_cell_rdy && ins_cell_rdy) |-> (tx_src == 2'd1));
  // R3
  idle_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_soc && tx_src == 2'd2) |-> (!user_cell_rdy && !ins_cell_rdy));
  // R7
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && cnt != LAST_POS) |=> $stable(tx_src));
  // R8
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_soc) |=> ($stable(tx_src) && !tx_soc));
  // R8
  stall_nopop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> (!user_rd && !ins_rd));
  // R9
  soc_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc == (cnt == '0));
  // R11
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({user_rd, ins_rd}));
  // R11
  user_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_rd |-> (tx_ready && tx_src == 2'd0));
  // R11
  ins_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_rd |-> (tx_ready && tx_src == 2'd1));
endmodule

bind atm_tx_cell_sel atm_tx_cell_sel_chk #(.CELL_BYTES(CELL_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .user_cell_rdy(user_cell_rdy),
  .ins_cell_rdy(ins_cell_rdy), .user_rd(user_rd), .ins_rd(ins_rd),
  .tx_ready(tx_ready), .tx_soc(tx_soc), .tx_src(tx_src)
);

// File: tb/sim_atm_tx_cell_sel.sv
module sim_atm_tx_cell_sel;
  localparam int PERIOD = 10;
  localparam int CELL   = 53;
  localparam int WDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       user_rd, ins_rd, tx_soc;
  logic [7:0] tx_byte;
  logic [1:0] tx_src;
  logic       tx_ready;
  logic       cfg_we;
  logic [2:0] cfg_addr;
  logic [7:0] cfg_wdata;

  // source models: written by driver, read pointer advanced by pop process
  logic [7:0] umem [0:1023];
  logic [7:0] imem [0:1023];
  int uwr = 0, urd = 0, iwr = 0, ird = 0;
  logic u_pop = 1'b0, i_pop = 1'b0;
  wire        user_cell_rdy = (uwr - urd) >= CELL;
  wire        ins_cell_rdy  = (iwr - ird) >= CELL;
  wire [7:0]  user_byte = umem[urd[9:0]];
  wire [7:0]  ins_byte  = imem[ird[9:0]];

  // scoreboard
  logic [7:0] eb   [0:2047];
  logic       esoc [0:2047];
  logic [1:0] esrc [0:2047];
  string      etag [0:2047];
  int ewr = 0, erd = 0;
  logic mon_en = 1'b0;
  int mchk = 0, mfail = 0, dchk = 0, dfail = 0;

  logic [7:0] hdr_m [5];
  logic [7:0] fill_m;

  always #(PERIOD/2) clk = ~clk;

  atm_tx_cell_sel u0 (
    .clk(clk), .rst_n(rst_n), .user_cell_rdy(user_cell_rdy), .user_byte(user_byte),
    .user_rd(user_rd), .ins_cell_rdy(ins_cell_rdy), .ins_byte(ins_byte), .ins_rd(ins_rd),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tx_ready(tx_ready),
    .tx_byte(tx_byte), .tx_soc(tx_soc), .tx_src(tx_src)
  );

  always @(posedge clk) begin
    if (u_pop) urd <= urd + 1;
    if (i_pop) ird <= ird + 1;
  end

  // monitor
  always @(negedge clk) begin
    u_pop <= user_rd;
    i_pop <= ins_rd;
    if (mon_en && tx_ready) begin
      mchk++;
      if (erd == ewr) begin
        mfail++;
        $display("FAIL R8 byte accepted with no expectation: got %h exp none", tx_byte);
      end else begin
        if (tx_byte !== eb[erd[10:0]] || tx_soc !== esoc[erd[10:0]] || tx_src !== esrc[erd[10:0]]) begin
          mfail++;
          $display("FAIL %s slot %0d: got byte %h soc %b src %0d, exp byte %h soc %b src %0d",
                   etag[erd[10:0]], erd, tx_byte, tx_soc, tx_src,
                   eb[erd[10:0]], esoc[erd[10:0]], esrc[erd[10:0]]);
        end
        erd <= erd + 1;
      end
    end
  end

  task automatic push_exp(input logic [7:0] b, input logic s, input logic [1:0] src, input string tag);
    eb[ewr[10:0]] = b; esoc[ewr[10:0]] = s; esrc[ewr[10:0]] = src; etag[ewr[10:0]] = tag;
    ewr++;
  endtask

  task automatic expect_seq(input logic [1:0] src, input logic [7:0] base, input string tag);
    for (int i = 0; i < CELL; i++) push_exp(base + 8'(i), i == 0, src, tag);
  endtask

  task automatic expect_idle(input string tag);
    for (int i = 0; i < CELL; i++) push_exp((i < 5) ? hdr_m[i] : fill_m, i == 0, 2'd2, tag);
  endtask

  task automatic add_user(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) umem[(uwr + i) % 1024] = base + 8'(i);
    uwr = uwr + n;
  endtask

  task automatic add_ins(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) imem[(iwr + i) % 1024] = base + 8'(i);
    iwr = iwr + n;
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    tx_ready = 1'b1;
    do begin @(posedge clk); #1; end while (erd != ewr);
    tx_ready = 1'b0;
  endtask

  task automatic dcheck(input logic ok, input string what, input int got, input int exp);
    dchk++;
    if (!ok) begin
      dfail++;
      $display("FAIL %s: got %0h exp %0h", what, got, exp);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    $display("FAIL watchdog expired: got running exp finished");
    $display("[TB] %0d tests run, %0d failed", mchk + dchk + 1, mfail + dfail + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tx_ready = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    hdr_m[0] = 8'h00; hdr_m[1] = 8'h00; hdr_m[2] = 8'h00; hdr_m[3] = 8'h01; hdr_m[4] = 8'h52;
    fill_m = 8'h6A;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R4 R9 reset state: idle cell at its first header byte
    @(negedge clk);
    dcheck(tx_soc === 1'b1, "R9 soc after reset", tx_soc, 1);
    dcheck(tx_src === 2'd2, "R3 src after reset", tx_src, 2);
    dcheck(tx_byte === 8'h00, "R4 first idle byte", tx_byte, 0);
    dcheck(!user_rd && !ins_rd, "R8 no pop while not ready", {user_rd, ins_rd}, 0);
    @(posedge clk); #1;

    // R4 R3 default idle cell
    expect_idle("R4 default idle");
    drain();

    // R1 user cell
    add_user(CELL, 8'h01);
    expect_seq(2'd0, 8'h01, "R1 user cell");
    drain();

    // R2 insertion cell
    add_ins(CELL, 8'hC0);
    expect_seq(2'd1, 8'hC0, "R2 insertion cell");
    drain();

    // R1 R2 priority with both ready
    add_user(CELL, 8'h10);
    add_ins(CELL, 8'h70);
    expect_seq(2'd0, 8'h10, "R1 user before insertion");
    expect_seq(2'd1, 8'h70, "R2 insertion after user");
    drain();

    // R1 partial cell not started, R7 completion mid idle cell
    add_user(20, 8'h40);
    expect_idle("R1 partial FIFO gives idle");
    expect_seq(2'd0, 8'h40, "R7 user after held idle");
    tx_ready = 1'b1;
    repeat (10) @(posedge clk); #1;
    add_user(CELL - 20, 8'h54);
    drain();

    // R7 insertion cell arriving during an insertion cell does not preempt... user arriving mid insertion cell
    add_ins(CELL, 8'h90);
    expect_seq(2'd1, 8'h90, "R7 insertion held");
    expect_seq(2'd0, 8'hA0, "R7 user next slot");
    tx_ready = 1'b1;
    repeat (5) @(posedge clk); #1;
    add_user(CELL, 8'hA0);
    drain();

    // R5 R6 programmed idle
    cfg_write(3'd0, 8'h11); cfg_write(3'd1, 8'h22); cfg_write(3'd2, 8'h33);
    cfg_write(3'd3, 8'h44); cfg_write(3'd4, 8'h55); cfg_write(3'd5, 8'hA5);
    hdr_m[0] = 8'h11; hdr_m[1] = 8'h22; hdr_m[2] = 8'h33; hdr_m[3] = 8'h44; hdr_m[4] = 8'h55;
    fill_m = 8'hA5;
    expect_idle("R5 R6 programmed idle");
    drain();

    // R10 write during idle cell
    expect_idle("R10 in-flight idle keeps old bytes");
    tx_ready = 1'b1;
    repeat (10) @(posedge clk); #1;
    cfg_write(3'd5, 8'hC3);
    cfg_write(3'd0, 8'h99);
    fill_m = 8'hC3; hdr_m[0] = 8'h99;
    expect_idle("R10 next idle uses new bytes");
    drain();

    // R8 stall mid cell
    add_user(CELL, 8'h80);
    expect_seq(2'd0, 8'h80, "R8 stalled user cell");
    tx_ready = 1'b1;
    repeat (20) @(posedge clk); #1;
    tx_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dcheck(tx_byte === eb[erd[10:0]], "R8 byte held in stall", tx_byte, eb[erd[10:0]]);
      dcheck(!tx_soc && tx_src === 2'd0, "R8 marker and source held", {tx_soc, tx_src}, 0);
      dcheck(!user_rd && !ins_rd, "R11 no strobe in stall", {user_rd, ins_rd}, 0);
    end
    @(posedge clk); #1;
    drain();

    // R11 nothing left in the sources, all bytes popped
    @(negedge clk);
    dcheck(urd == uwr, "R11 user bytes popped", urd, uwr);
    dcheck(ird == iwr, "R11 insertion bytes popped", ird, iwr);

    $display("[TB] %0d tests run, %0d failed", mchk + dchk, mfail + dfail);
    $finish;
  end
endmodule